// File: doc/BRIEF.md
# Cascade Backplane Vector Arbiter

Several repeater chips can be stacked on one shared backplane, but only one of them may drive the backplane data lines at a time. This block decides, for one chip, whether that chip owns the backplane. Each chip holds a unique 5-bit identifier. While the chip has local receive activity, it pulls low every backplane vector line whose identifier bit is 0. The lines are open-collector and wired-AND, so a line stays high only when no chip pulls it low. One clock later the chip compares the value it reads back with its own identifier. A chip that sees its own identifier wins ownership. A chip that sees a different value has lost to a chip with a smaller identifier.

The winner first releases the external transceiver enable for one turnaround cycle. It then raises the outward-direction control and the data-line output enable. The loser keeps its data lines tri-stated and raises collision-out until its local activity ends. Collision-out is also raised when two or more local ports receive at once. An identifier of all ones equals the idle bus value, and it raises an error flag.

The state machine has four states. `ST_IDLE` holds no activity. `ST_TURN` is the one-cycle turnaround. `ST_OWN` means the chip drives the bus. `ST_LOST` means ownership was lost and is held.

Its transitions are:
- IDLE→TURN: the chip is active and the read-back matches.
- IDLE→LOST: the chip is active and the read-back differs.
- TURN→OWN: the chip is still active and the read-back still matches.
- TURN→LOST and OWN→LOST: the chip is active and the read-back differs.
- TURN, OWN or LOST→IDLE: local activity has ended.

Top module: `cascade_vec_arb`

## Requirements
- R1: The identifier present on `id_strap` at the first rising clock edge after reset release is captured and used from then on. Later changes of `id_strap` have no effect until the next reset.
- R2: While `active_out` is 1, `vec_pull[i]` is 1 (pull the line low) exactly where bit i of the captured identifier is 0. While `active_out` is 0, `vec_pull` is 0.
- R3: `active_out` is 1 in the same cycle that any bit of `port_rx` is 1, once the identifier has been captured. Otherwise it is 0.
- R4: Suppose the read-back `bus_vec` equals the identifier on the edge that ends the first active cycle. In the next cycle `bus_en` is 0, while `dir_out` and `data_oe` stay 0. In the cycle after that, if activity and the match persist, `dir_out`, `data_oe` and `bus_en` are all 1.
- R5: If `bus_vec` differs from the identifier at any clock edge while the chip is active, then from the next cycle `dir_out` and `data_oe` are 0 and `col_out` is 1. This holds until activity ends, even if the bus matches again.
- R6: `col_out` is 1 in the same cycle that two or more bits of `port_rx` are 1.
- R7: `bus_en` is 0 only during the single turnaround cycle. It is 1 in reset, when idle, while owning, while lost, and when going from output back to input.
- R8: `id_err` is 1 when the captured identifier is 5'h1F, and 0 otherwise, including before capture.
- R9: One cycle after `port_rx` becomes all zero, `dir_out`, `data_oe` and the held `col_out` return to 0.
- R10: Two instances wire-ANDed with identifiers 00010 and 00011 and activated in the same cycle give ownership to 00010 only. The instance with 00011 shows `col_out` at 1 with `dir_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_strap | input | ID_W | Identifier straps, captured after reset |
| port_rx | input | PORTS | Per-port receive activity |
| bus_vec | input | ID_W | Read-back of the wired-AND vector bus |
| vec_pull | output | ID_W | Pull-down requests, 1 = pull that line low |
| active_out | output | 1 | Local activity, enables the vector drivers |
| dir_out | output | 1 | Transceiver direction, 1 = outward |
| bus_en | output | 1 | Transceiver enable, 0 during turnaround |
| data_oe | output | 1 | Output enable for data, error, valid and clock lines |
| col_out | output | 1 | Collision indication to other chips |
| id_err | output | 1 | Identifier equals the idle bus value |

## Verification
Two functions can fall in the same cycle:
- Collision-out can be raised by the local multi-port condition and by held loss of ownership.
- A new read-back mismatch can arrive in the same cycle as the turnaround, or while the chip already owns the bus.

The bench provokes these cases in three ways:
- An extra pull-down source on the wired-AND bus steals ownership from a chip that already owns it. The source is then released, so the bench can see that the loss stays held.
- Two instances are started in the same cycle.
- Several local ports are activated together while the chip arbitrates.

A behavioural model of both instances predicts every output every cycle, and the two are compared each cycle.

// File: rtl/cva_pkg.sv
package cva_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TURN = 2'd1,
        ST_OWN  = 2'd2,
        ST_LOST = 2'd3
    } arb_state_t;
endpackage

// File: rtl/cva_id_latch.sv
module cva_id_latch #(
    parameter int ID_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] id_strap,
    output logic [ID_W-1:0] id_q,
    output logic            id_valid,
    output logic            id_err
);
    localparam logic [ID_W-1:0] IDLE_VEC = {ID_W{1'b1}};

    // Capture once on the first edge after reset release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q     <= '0;
            id_valid <= 1'b0;
        end else if (!id_valid) begin
            id_q     <= id_strap;
            id_valid <= 1'b1;
        end
    end

    assign id_err = id_valid && (id_q == IDLE_VEC);

    AST_ID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(id_valid) |-> $stable(id_q)); // R1
endmodule

// File: rtl/cva_vec_drive.sv
module cva_vec_drive #(
    parameter int ID_W  = 5,
    parameter int PORTS = 8
) (
    input  logic [ID_W-1:0]  id_q,
    input  logic             id_valid,
    input  logic [PORTS-1:0] port_rx,
    output logic             active,
    output logic             multi_rx,
    output logic [ID_W-1:0]  vec_pull
);
    localparam int CNT_W = $clog2(PORTS + 1);

    logic [CNT_W-1:0] rx_count;

    always_comb begin
        rx_count = '0;
        for (int i = 0; i < PORTS; i++) begin
            rx_count = rx_count + CNT_W'(port_rx[i]);
        end
    end

    assign active   = id_valid && (|port_rx);
    assign multi_rx = (rx_count > CNT_W'(1));

    // Open-collector model: pull low where the identifier bit is zero
    generate
        for (genvar b = 0; b < ID_W; b++) begin : g_pull
            assign vec_pull[b] = active && !id_q[b];
        end
    endgenerate
endmodule

// File: rtl/cva_fsm.sv
module cva_fsm
    import cva_pkg::*;
#(
    parameter int ID_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            multi_rx,
    input  logic [ID_W-1:0] id_q,
    input  logic [ID_W-1:0] bus_vec,
    output logic            dir_out,
    output logic            bus_en,
    output logic            data_oe,
    output logic            col_out
);
    arb_state_t state_q, state_d;
    logic       vec_match;

    assign vec_match = (bus_vec == id_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (active) state_d = vec_match ? ST_TURN : ST_LOST;
            ST_TURN,
            ST_OWN:  begin
                if (!active)        state_d = ST_IDLE;
                else if (vec_match) state_d = ST_OWN;
                else                state_d = ST_LOST;
            end
            ST_LOST: if (!active) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        dir_out = 1'b0;
        bus_en  = 1'b1;
        data_oe = 1'b0;
        col_out = multi_rx;
        unique case (state_q)
            ST_IDLE: ;
            ST_TURN: bus_en = 1'b0;
            ST_OWN:  begin
                dir_out = 1'b1;
                data_oe = 1'b1;
            end
            ST_LOST: col_out = 1'b1;
            default: ;
        endcase
    end

    AST_DIR_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dir_out) |-> $past(!bus_en)); // R4
    AST_OWN_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        dir_out |-> $past(vec_match && active)); // R4
    AST_MISMATCH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !vec_match) |=> !dir_out); // R5
    AST_TURN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> bus_en); // R7
endmodule

// File: rtl/cascade_vec_arb.sv
module cascade_vec_arb #(
    parameter int ID_W  = 5,
    parameter int PORTS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ID_W-1:0]  id_strap,
    input  logic [PORTS-1:0] port_rx,
    input  logic [ID_W-1:0]  bus_vec,
    output logic [ID_W-1:0]  vec_pull,
    output logic             active_out,
    output logic             dir_out,
    output logic             bus_en,
    output logic             data_oe,
    output logic             col_out,
    output logic             id_err
);
    logic [ID_W-1:0] id_q;
    logic            id_valid;
    logic            multi_rx;

    cva_id_latch #(.ID_W(ID_W)) u_id (
        .clk      (clk),
        .rst_n    (rst_n),
        .id_strap (id_strap),
        .id_q     (id_q),
        .id_valid (id_valid),
        .id_err   (id_err)
    );

    cva_vec_drive #(.ID_W(ID_W), .PORTS(PORTS)) u_drv (
        .id_q     (id_q),
        .id_valid (id_valid),
        .port_rx  (port_rx),
        .active   (active_out),
        .multi_rx (multi_rx),
        .vec_pull (vec_pull)
    );

    cva_fsm #(.ID_W(ID_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active_out),
        .multi_rx (multi_rx),
        .id_q     (id_q),
        .bus_vec  (bus_vec),
        .dir_out  (dir_out),
        .bus_en   (bus_en),
        .data_oe  (data_oe),
        .col_out  (col_out)
    );
endmodule

// File: tb/cascade_vec_arb_test.sv
module cascade_vec_arb_test;
    localparam int ID_W  = 5;
    localparam int PORTS = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n = 1'b0;
    logic [ID_W-1:0]  strap_a = 5'b00010;
    logic [ID_W-1:0]  strap_b = 5'b00011;
    logic [ID_W-1:0]  ext_pull = '0;
    logic [PORTS-1:0] rx_a = '0;
    logic [PORTS-1:0] rx_b = '0;

    wire [ID_W-1:0] pull_a, pull_b, bus_vec;
    wire act_a, dir_a, en_a, oe_a, col_a, err_a;
    wire act_b, dir_b, en_b, oe_b, col_b, err_b;

    assign bus_vec = ~(pull_a | pull_b | ext_pull);

    cascade_vec_arb #(.ID_W(ID_W), .PORTS(PORTS)) uut (
        .clk(clk), .rst_n(rst_n), .id_strap(strap_a), .port_rx(rx_a),
        .bus_vec(bus_vec), .vec_pull(pull_a), .active_out(act_a),
        .dir_out(dir_a), .bus_en(en_a), .data_oe(oe_a),
        .col_out(col_a), .id_err(err_a)
    );

    cascade_vec_arb #(.ID_W(ID_W), .PORTS(PORTS)) uut_b (
        .clk(clk), .rst_n(rst_n), .id_strap(strap_b), .port_rx(rx_b),
        .bus_vec(bus_vec), .vec_pull(pull_b), .active_out(act_b),
        .dir_out(dir_b), .bus_en(en_b), .data_oe(oe_b),
        .col_out(col_b), .id_err(err_b)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    bit mon_on = 1'b0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] actv, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actv, expv);
        end
    endtask

    // Reference model: 0 idle, 1 turnaround, 2 owner, 3 lost
    int             m_st  [2] = '{0, 0};
    bit             m_cap [2] = '{0, 0};
    bit [ID_W-1:0]  m_id  [2] = '{5'd0, 5'd0};

    function automatic bit [ID_W-1:0] exp_pull(int c);
        bit [PORTS-1:0] rx = (c == 0) ? rx_a : rx_b;
        return (m_cap[c] && (rx != 0)) ? ~m_id[c] : '0;
    endfunction

    always @(posedge clk) begin
        bit [ID_W-1:0] bus_m;
        bus_m = ~(exp_pull(0) | exp_pull(1) | ext_pull);
        for (int c = 0; c < 2; c++) begin
            bit act;
            bit match;
            act   = m_cap[c] && (((c == 0) ? rx_a : rx_b) != 0);
            match = (bus_m == m_id[c]);
            if (!rst_n) begin
                m_st[c]  = 0;
                m_cap[c] = 0;
                m_id[c]  = '0;
            end else begin
                case (m_st[c])
                    0:       m_st[c] = act ? (match ? 1 : 3) : 0;
                    1, 2:    m_st[c] = !act ? 0 : (match ? 2 : 3);
                    default: m_st[c] = act ? 3 : 0;
                endcase
                if (!m_cap[c]) begin
                    m_cap[c] = 1;
                    m_id[c]  = (c == 0) ? strap_a : strap_b;
                end
            end
        end
        mon_on = 1'b1;
    end

    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            for (int c = 0; c < 2; c++) begin
                bit [PORTS-1:0] rx;
                bit [ID_W-1:0]  p;
                bit a, d, e, o, k, r;
                rx = (c == 0) ? rx_a : rx_b;
                p  = (c == 0) ? pull_a : pull_b;
                a  = (c == 0) ? act_a : act_b;
                d  = (c == 0) ? dir_a : dir_b;
                e  = (c == 0) ? en_a  : en_b;
                o  = (c == 0) ? oe_a  : oe_b;
                k  = (c == 0) ? col_a : col_b;
                r  = (c == 0) ? err_a : err_b;
                chk(p == exp_pull(c), "R2 vec_pull", p, exp_pull(c));
                chk(a == (m_cap[c] && rx != 0), "R3 active_out", a, m_cap[c] && rx != 0);
                chk(d == (m_st[c] == 2), "R4 dir_out", d, m_st[c] == 2);
                chk(o == (m_st[c] == 2), "R4 data_oe", o, m_st[c] == 2);
                chk(e == (m_st[c] != 1), "R7 bus_en", e, m_st[c] != 1);
                chk(k == (m_st[c] == 3 || $countones(rx) > 1), "R6 col_out", k,
                    m_st[c] == 3 || $countones(rx) > 1);
                chk(r == (m_cap[c] && m_id[c] == 5'h1F), "R8 id_err", r,
                    m_cap[c] && m_id[c] == 5'h1F);
            end
        end
    end

    task automatic drive_slot();
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(en_a == 1'b1, "R7 reset bus_en", en_a, 1);
        chk(dir_a == 1'b0, "R4 reset dir_out", dir_a, 0);
        chk(err_a == 1'b0, "R8 reset id_err", err_a, 0);

        drive_slot(); rst_n = 1'b1;
        drive_slot(); strap_a = 5'h1F; rx_a = 8'h01;
        @(negedge clk);
        chk(pull_a == 5'b11101, "R1 strap change ignored", pull_a, 5'b11101);
        @(negedge clk);
        chk(!en_a && !dir_a, "R4 turnaround", {en_a, dir_a}, 2'b00);
        @(negedge clk);
        chk(dir_a && oe_a && en_a, "R4 owned", {dir_a, oe_a, en_a}, 3'b111);
        drive_slot(); rx_a = '0;
        @(negedge clk);
        @(negedge clk);
        chk(!dir_a && !oe_a, "R9 release", {dir_a, oe_a}, 2'b00);

        drive_slot(); rx_a = 8'h04; rx_b = 8'h10;
        @(negedge clk);
        chk(bus_vec == 5'b00010, "R10 wired-AND", bus_vec, 5'b00010);
        @(negedge clk);
        chk(!en_a && col_b && !col_a, "R10 arbitration", {en_a, col_b, col_a}, 3'b010);
        @(negedge clk);
        chk(dir_a && !dir_b && !oe_b, "R10 owner", {dir_a, dir_b, oe_b}, 3'b100);
        drive_slot(); rx_b = '0;
        @(negedge clk);
        @(negedge clk);
        chk(!col_b, "R9 lost cleared", col_b, 0);

        drive_slot(); ext_pull = 5'b00010;
        drive_slot(); ext_pull = '0;
        @(negedge clk);
        chk(!dir_a && col_a, "R5 ownership lost", {dir_a, col_a}, 2'b01);
        @(negedge clk);
        chk(!dir_a && !oe_a && col_a, "R5 loss held", {dir_a, oe_a, col_a}, 3'b001);
        drive_slot(); rx_a = '0;
        @(negedge clk);
        @(negedge clk);
        chk(!col_a, "R9 col cleared", col_a, 0);

        drive_slot(); rx_a = 8'h03;
        @(negedge clk);
        chk(col_a, "R6 multi-port", col_a, 1);
        repeat (3) @(negedge clk);
        chk(col_a && dir_a, "R6 multi while owning", {col_a, dir_a}, 2'b11);
        drive_slot(); rx_a = '0;
        repeat (2) @(negedge clk);

        drive_slot(); rst_n = 1'b0;
        drive_slot(); rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(err_a, "R8 idle id flagged", err_a, 1);
        chk(!err_b, "R8 valid id clear", err_b, 0);
        repeat (2) @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule